// File: doc/BRIEF.md
# Keyed Configuration-Port Watchdog

This block is a watchdog timer that sits behind a byte-wide configuration port made of an index register and a data register. Software first opens the port with a fixed key: the byte 0x87 written to the index port on two index writes in a row. It then selects a logical page and reads or writes the watchdog registers through the data port. Finally it closes the port again with the byte 0xAA. While the port is closed, data writes do nothing and every read returns 0xFF.

Once enabled with a nonzero value, the 8-bit down-counter steps once per unit tick. A prescaler derives the unit tick from the clock, and a unit bit makes that tick one second or one minute long. When the counter steps from 1 to 0, the block drives a single-cycle reset pulse and latches a sticky expired flag, which software clears. Keyboard and mouse interrupt pulses can reload the last programmed timer value, each only when its own enable bit is set.

Top module: `cfg_watchdog`

## Requirements
- R1: The port opens only after two consecutive index writes of 0x87. Any other index byte between them restarts the key. The page register resets to 0.
- R2: An index write of 0xAA closes the port. After that, data writes change no register and reads return 0xFF until the key is given again. The page and index are kept across the close.
- R3: Index 0x07 is the page register and can be read and written whenever the port is open. The watchdog registers respond only when the page is 8. On any other page their reads return 0xFF and their writes are dropped.
- R4: The data port reads 0xFF while the port is closed and for any index that is not implemented.
- R5: Register 0x30 bit 0 is the enable bit. While it is 0, the counter holds its value.
- R6: Register 0xF5 bit 3 selects the unit: 0 means seconds of TICKS_PER_SEC clocks, 1 means minutes of SECS_PER_MIN seconds. Only bit 3 is stored; the other bits read 0.
- R7: A write to register 0xF6 loads both the counter and the reload value, and restarts the prescaler. A read of 0xF6 returns the live count.
- R8: When enabled with a count of N, the reset output pulses high for exactly one cycle, N units after the clock edge that writes the enable. At the same time the sticky flag, read as register 0x30 bit 1, is set and the count reads 0.
- R9: In register 0xF7, bit 6 lets a keyboard pulse reload the counter from the reload value, and bit 7 does the same for a mouse pulse. A pulse whose bit is clear is ignored. The other bits read 0.
- R10: A count of 0 never produces a reset, whether or not the watchdog is enabled.
- R11: Writing 1 to register 0x30 bit 1 clears the sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_we_i | input | 1 | Index-port write strobe (has priority over a data write) |
| dat_we_i | input | 1 | Data-port write strobe |
| wdata_i | input | 8 | Write byte for either port |
| rdata_o | output | 8 | Data-port read value for the current index |
| kbd_irq_i | input | 1 | Keyboard interrupt pulse |
| mouse_irq_i | input | 1 | Mouse interrupt pulse |
| wdt_rst_o | output | 1 | One-cycle reset pulse on expiry |
| expired_o | output | 1 | Sticky expired flag |

## Verification
The assertions check four things on every cycle. A lock command is always followed by 0xFF reads. The reset pulse is one cycle long and only ever follows a count of 1. The sticky flag is set whenever the pulse is. A disabled counter without a load stays still. Other behaviour needs the bench's scenarios: the key restart, page gating, exact expiry cycles in both units, selective reload by keyboard or mouse, the silence of a zero count, and the clearing of the flag.

// File: rtl/cfgwd_pkg.sv
package cfgwd_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] IDX_PAGE  = 8'h07;
  localparam logic [7:0] WD_PAGE   = 8'h08;
  localparam logic [7:0] IDX_EN    = 8'h30;
  localparam logic [7:0] IDX_UNIT  = 8'hF5;
  localparam logic [7:0] IDX_TMR   = 8'hF6;
  localparam logic [7:0] IDX_RLD   = 8'hF7;

  typedef enum logic [1:0] {
    KS_CLOSED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/cfgwd_key_fsm.sv
module cfgwd_key_fsm
  import cfgwd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_we_i,
  input  logic       dat_we_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic [7:0] idx_o,
  output logic [7:0] page_o
);
  key_state_e st_q;
  logic [7:0] idx_q, page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= KS_CLOSED;
      idx_q  <= '0;
      page_q <= '0;
    end else if (idx_we_i) begin
      unique case (st_q)
        KS_CLOSED: st_q <= (wdata_i == KEY_OPEN) ? KS_HALF : KS_CLOSED;
        KS_HALF:   st_q <= (wdata_i == KEY_OPEN) ? KS_OPEN : KS_CLOSED;
        KS_OPEN: begin
          if (wdata_i == KEY_CLOSE) st_q  <= KS_CLOSED;
          else                      idx_q <= wdata_i;
        end
        default:   st_q <= KS_CLOSED;
      endcase
    end else if (dat_we_i && st_q == KS_OPEN && idx_q == IDX_PAGE) begin
      page_q <= wdata_i;
    end
  end

  assign open_o = (st_q == KS_OPEN);
  assign idx_o  = idx_q;
  assign page_o = page_q;
endmodule

// File: rtl/cfgwd_regs.sv
module cfgwd_regs
  import cfgwd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  input  logic       hit_i,
  output logic       en_o,
  output logic       unit_o,
  output logic       kbd_en_o,
  output logic       ms_en_o,
  output logic       expired_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      unit_o   <= 1'b0;
      kbd_en_o <= 1'b0;
      ms_en_o  <= 1'b0;
    end else if (wr_i) begin
      if (idx_i == IDX_EN)   en_o   <= wdata_i[0];
      if (idx_i == IDX_UNIT) unit_o <= wdata_i[3];
      if (idx_i == IDX_RLD) begin
        kbd_en_o <= wdata_i[6];
        ms_en_o  <= wdata_i[7];
      end
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     expired_o <= 1'b0;
    else if (hit_i)                                  expired_o <= 1'b1;
    else if (wr_i && idx_i == IDX_EN && wdata_i[1])  expired_o <= 1'b0;
  end
endmodule

// File: rtl/cfgwd_prescaler.sv
module cfgwd_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 8,
  parameter int unsigned SECS_PER_MIN  = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic unit_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int unsigned MW = (SECS_PER_MIN  > 1) ? $clog2(SECS_PER_MIN)  : 1;

  logic [PW-1:0] pc_q;
  logic [MW-1:0] mc_q;
  logic          sec_tick, min_tick;

  assign sec_tick = !clr_i && (pc_q == PW'(TICKS_PER_SEC - 1));
  assign min_tick = sec_tick && (mc_q == MW'(SECS_PER_MIN - 1));
  assign tick_o   = unit_i ? min_tick : sec_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      mc_q <= '0;
    end else if (clr_i) begin
      pc_q <= '0;
      mc_q <= '0;
    end else if (sec_tick) begin
      pc_q <= '0;
      mc_q <= min_tick ? '0 : mc_q + MW'(1);
    end else begin
      pc_q <= pc_q + PW'(1);
    end
  end
endmodule

// File: rtl/cfgwd_counter.sv
module cfgwd_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_tmr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          irq_load_i,
  input  logic          en_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o,
  output logic          rst_o
);
  logic [CW-1:0] cnt_q, rld_q;
  logic          step;

  assign step  = en_i && tick_i && !wr_tmr_i && !irq_load_i && (cnt_q != '0);
  assign hit_o = step && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      rst_o <= 1'b0;
    end else begin
      rst_o <= hit_o;
      if (wr_tmr_i) begin
        cnt_q <= wdata_i;
        rld_q <= wdata_i;
      end else if (irq_load_i) begin
        cnt_q <= rld_q;
      end else if (step) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cfg_watchdog.sv
module cfg_watchdog
  import cfgwd_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 8,
  parameter int unsigned SECS_PER_MIN  = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_we_i,
  input  logic       dat_we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       kbd_irq_i,
  input  logic       mouse_irq_i,
  output logic       wdt_rst_o,
  output logic       expired_o
);
  logic       open, wd_wr, wr_tmr, irq_load, cnt_load, tick, hit;
  logic       en, unit, kbd_en, ms_en;
  logic [7:0] idx, page, cnt;

  cfgwd_key_fsm u_key (
    .clk_i, .rst_ni, .idx_we_i, .dat_we_i, .wdata_i,
    .open_o(open), .idx_o(idx), .page_o(page)
  );

  assign wd_wr    = dat_we_i && !idx_we_i && open && (page == WD_PAGE);
  assign wr_tmr   = wd_wr && (idx == IDX_TMR);
  assign irq_load = (kbd_irq_i && kbd_en) || (mouse_irq_i && ms_en);
  assign cnt_load = wr_tmr || irq_load;

  cfgwd_regs u_regs (
    .clk_i, .rst_ni, .wr_i(wd_wr), .idx_i(idx), .wdata_i, .hit_i(hit),
    .en_o(en), .unit_o(unit), .kbd_en_o(kbd_en), .ms_en_o(ms_en),
    .expired_o
  );

  cfgwd_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_MIN(SECS_PER_MIN)) u_pre (
    .clk_i, .rst_ni, .clr_i(!en || cnt_load), .unit_i(unit), .tick_o(tick)
  );

  cfgwd_counter #(.CW(8)) u_cnt (
    .clk_i, .rst_ni, .wr_tmr_i(wr_tmr), .wdata_i, .irq_load_i(irq_load),
    .en_i(en), .tick_i(tick), .cnt_o(cnt), .hit_o(hit), .rst_o(wdt_rst_o)
  );

  always_comb begin
    rdata_o = 8'hFF;
    if (open) begin
      if (idx == IDX_PAGE) rdata_o = page;
      else if (page == WD_PAGE) begin
        unique case (idx)
          IDX_EN:   rdata_o = {6'b0, expired_o, en};
          IDX_UNIT: rdata_o = {4'b0, unit, 3'b0};
          IDX_TMR:  rdata_o = cnt;
          IDX_RLD:  rdata_o = {ms_en, kbd_en, 6'b0};
          default:  rdata_o = 8'hFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_watchdog_chk.sv
module cfg_watchdog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       idx_we_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       wdt_rst_o,
  input logic       expired_o,
  input logic       en,
  input logic [7:0] cnt,
  input logic       cnt_load
);
  a_r2_close_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_we_i && wdata_i == 8'hAA) |=> (rdata_o == 8'hFF));

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  a_r8_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> expired_o);

  a_r10_pulse_from_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> ($past(cnt) == 8'd1));

  a_r5_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cnt_load) |=> $stable(cnt));
endmodule

bind cfg_watchdog cfg_watchdog_chk u_chk (
  .clk_i, .rst_ni, .idx_we_i, .wdata_i, .rdata_o, .wdt_rst_o, .expired_o,
  .en(en), .cnt(cnt), .cnt_load(cnt_load)
);

// File: tb/tb_cfg_watchdog.sv
module tb_cfg_watchdog;
  localparam int TPS = 8;
  localparam int SPM = 60;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic idx_we = 1'b0, dat_we = 1'b0, kbd = 1'b0, mouse = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic wdt_rst, expired;
  int n_chk = 0, n_bad = 0;

  logic [7:0] m_tmr, m_unit, m_rld;

  always #5 clk = ~clk;

  cfg_watchdog #(.TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM)) dut (
    .clk_i(clk), .rst_ni, .idx_we_i(idx_we), .dat_we_i(dat_we), .wdata_i(wdata),
    .rdata_o(rdata), .kbd_irq_i(kbd), .mouse_irq_i(mouse),
    .wdt_rst_o(wdt_rst), .expired_o(expired)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idx_wr(input logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; wdata = v;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic dat_wr(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
    idx_wr(i); dat_wr(v);
  endtask

  task automatic rd(input logic [7:0] i, output logic [7:0] v);
    idx_wr(i); v = rdata;
  endtask

  task automatic unlock();
    idx_wr(8'h87); idx_wr(8'h87);
  endtask

  // enable write just committed; expect pulse exactly n cycles later
  task automatic wait_pulse(input string req, input int n);
    int early = 0;
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      if (wdt_rst) early++;
    end
    chk({req, " no early pulse"}, 8'(early), 8'd0);
    @(negedge clk); chk({req, " pulse high"}, {7'b0, wdt_rst}, 8'd1);
    @(negedge clk); chk({req, " pulse one cycle"}, {7'b0, wdt_rst}, 8'd0);
  endtask

  task automatic quiet(input string req, input int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
    chk(req, 8'(seen), 8'd0);
  endtask

  function automatic logic [7:0] mask_of(input logic [7:0] i, input logic [7:0] v);
    case (i)
      8'hF5:   return v & 8'h08;
      8'hF7:   return v & 8'hC0;
      default: return v;
    endcase
  endfunction

  task automatic pulse_irq(input bit is_kbd);
    @(negedge clk);
    if (is_kbd) kbd = 1'b1; else mouse = 1'b1;
    @(negedge clk); kbd = 1'b0; mouse = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, r, sel_idx;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R4 reset read closed", rdata, 8'hFF);
    chk("R8 reset pulse low", {7'b0, wdt_rst}, 8'd0);
    chk("R8 reset flag low", {7'b0, expired}, 8'd0);

    // R1 key restart
    idx_wr(8'h87); idx_wr(8'h55); idx_wr(8'h87); idx_wr(8'h07);
    chk("R1 broken key stays closed", rdata, 8'hFF);
    unlock(); idx_wr(8'h07);
    chk("R1 open, page reset 0", rdata, 8'h00);

    // R3 page gating
    idx_wr(8'hF6); dat_wr(8'h33);
    chk("R3 wrong page reads FF", rdata, 8'hFF);
    reg_wr(8'h07, 8'h08);
    rd(8'hF6, r); chk("R3 wrong-page write dropped", r, 8'h00);
    rd(8'h07, r); chk("R3 page readback", r, 8'h08);
    rd(8'h42, r); chk("R4 unimplemented index", r, 8'hFF);

    m_tmr = 8'h00; m_unit = 8'h00; m_rld = 8'h00;
    for (int it = 0; it < 40; it++) begin
      v = 8'($urandom);
      case ($urandom % 3)
        0: begin sel_idx = 8'hF6; m_tmr = v; end
        1: begin sel_idx = 8'hF5; m_unit = mask_of(8'hF5, v); end
        default: begin sel_idx = 8'hF7; m_rld = mask_of(8'hF7, v); end
      endcase
      reg_wr(sel_idx, v);
      rd(sel_idx, r);
      chk(sel_idx == 8'hF6 ? "R7 timer readback" :
          sel_idx == 8'hF5 ? "R6 unit readback" : "R9 reload-select readback",
          r, sel_idx == 8'hF6 ? m_tmr : sel_idx == 8'hF5 ? m_unit : m_rld);
      if (($urandom % 4) == 0) begin
        idx_wr(8'hF6); idx_wr(8'hAA);
        chk("R2 closed read", rdata, 8'hFF);
        dat_wr(8'($urandom));
        unlock();
        chk("R2 closed write ignored", rdata, m_tmr);
      end
    end
    reg_wr(8'hF5, 8'h00); reg_wr(8'hF7, 8'h00);

    // R8 seconds expiry
    reg_wr(8'hF6, 8'd3); reg_wr(8'h30, 8'h01);
    wait_pulse("R8 seconds", 3 * TPS);
    chk("R8 flag set", {7'b0, expired}, 8'd1);
    rd(8'hF6, r); chk("R8 count at zero", r, 8'h00);
    quiet("R10 zero after expiry", 4 * TPS);
    rd(8'h30, r); chk("R8 status bits", r, 8'h03);
    reg_wr(8'h30, 8'h02);
    chk("R11 flag cleared", {7'b0, expired}, 8'd0);

    // R10 zero count enabled
    reg_wr(8'hF6, 8'd0); reg_wr(8'h30, 8'h01);
    quiet("R10 zero count silent", 5 * TPS);
    chk("R10 no flag", {7'b0, expired}, 8'd0);
    reg_wr(8'h30, 8'h00);

    // R5 disabled holds
    reg_wr(8'hF6, 8'd9);
    repeat (3 * TPS) @(negedge clk);
    rd(8'hF6, r); chk("R5 disabled holds", r, 8'd9);

    // R6 minutes
    reg_wr(8'hF5, 8'h08); reg_wr(8'hF6, 8'd2); reg_wr(8'h30, 8'h01);
    wait_pulse("R6 minutes", 2 * SPM * TPS);
    reg_wr(8'h30, 8'h02); reg_wr(8'hF5, 8'h00);

    // R9 selective reload
    reg_wr(8'hF7, 8'h40); reg_wr(8'hF6, 8'd5); reg_wr(8'h30, 8'h01);
    repeat (2 * TPS) @(negedge clk);
    reg_wr(8'h30, 8'h00);
    rd(8'hF6, r); chk("R9 count ran to 3", r, 8'd3);
    pulse_irq(1'b0);
    rd(8'hF6, r); chk("R9 mouse ignored", r, 8'd3);
    pulse_irq(1'b1);
    rd(8'hF6, r); chk("R9 keyboard reload", r, 8'd5);
    reg_wr(8'hF7, 8'h80); reg_wr(8'h30, 8'h01);
    repeat (TPS) @(negedge clk);
    reg_wr(8'h30, 8'h00);
    rd(8'hF6, r); chk("R9 count ran to 4", r, 8'd4);
    pulse_irq(1'b1);
    rd(8'hF6, r); chk("R9 keyboard ignored", r, 8'd4);
    pulse_irq(1'b0);
    rd(8'hF6, r); chk("R9 mouse reload", r, 8'd5);

    idx_wr(8'hAA);
    dat_wr(8'h00);
    unlock(); idx_wr(8'hF6);
    chk("R2 page kept, write ignored", rdata, 8'd5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule